// File: doc/BRIEF.md
# Single-Stream DMA Transfer Sequencer

This block runs one DMA stream that moves items between a peripheral and memory. Software programs the stream through a configuration write port. One write strobe loads every field while the stream is idle: enable, direction, circular and double-buffer modes, starting target, item count, two memory base addresses, a peripheral address, item size, address increment enables, FIFO threshold and burst size, and interrupt enables. While the stream runs, a configuration write can only ask it to stop.

Each peripheral request strobe produces one simplified bus beat. The beat holds its addresses until the bus acknowledges it. Each acknowledged beat counts one item off the remaining-item counter and steps the addresses. When the counter runs out, the stream either stops (normal mode) or reloads and continues (circular or double-buffer mode). In double-buffer mode it also swaps memory buffers. Four sticky status flags report half transfer, transfer complete, bus error and FIFO configuration error. They drive a single interrupt line through per-flag enables and are cleared by a write-one-to-clear input.

Top module: `dma_stream_seq`

## Requirements
- R1: After reset `en_rd`, `ct_rd`, `remain`, `flags`, `irq` and `beat_vld` are all 0.
- R2: A configuration write with `cfg_en`=1 while idle (and no flag set, no FIFO error) sets `en_rd` and loads `remain` with `cfg_count`. Each `req` then raises one beat (`beat_vld` held until `beat_ack`). Every acknowledged error-free beat lowers `remain` by one.
- R3: The beat's memory address starts at the active buffer base and, when `cfg_minc`=1, advances by 1<<`cfg_size` bytes after each beat (`cfg_size` 0=byte, 1=halfword, 2=word). The peripheral address stays at `cfg_paddr` unless `cfg_pinc`=1, in which case it advances by the same step.
- R4: Flag bit 0 (half) sets when a beat leaves `remain` equal to the programmed count shifted right by one. Flag bit 1 (complete) sets when a beat leaves `remain` at 0. `irq` is (flag0 & `cfg_ie[0]`) | (flag1 & `cfg_ie[1]`) | ((flag2|flag3) & `cfg_ie[2]`).
- R5: In normal mode (`cfg_circ`=0, `cfg_dbuf`=0), the beat that brings `remain` to 0 also clears `en_rd`.
- R6: In circular mode, the beat that brings `remain` to 0 reloads the count, keeps `en_rd` at 1, and returns both addresses to their base values.
- R7: In double-buffer mode, buffer 0 is `cfg_m0addr` and buffer 1 is `cfg_m1addr`. The stream starts on buffer `cfg_ct`, and `ct_rd` toggles at each wrap. The next beat uses the base of the new buffer.
- R8: Writing `cfg_en`=0 while a beat is in flight leaves `en_rd` at 1 until that beat is acknowledged and counted. Writing it with no beat in flight clears `en_rd` at the next edge. All other fields of a write made while `en_rd`=1 are ignored.
- R9: With `cfg_pfc`=1 (peripheral controls the flow), `cfg_count` is ignored and `remain` becomes all ones at enable.
- R10: With `cfg_fifo_en`=1, enabling checks the FIFO threshold against the burst size. The threshold is (`cfg_fth`+1)/4 of a 16-byte FIFO. A burst is 1, 4, 8 or 16 items for `cfg_mburst` 0..3, times the item size. If the threshold is not a whole number of bursts, flag bit 3 sets and `en_rd` stays 0.
- R11: Flags are sticky and are cleared only by a 1 on the matching bit of `flag_clr`. When a flag is set and cleared in the same cycle, the set wins.
- R12: An enable write while any flag is set is refused, and `en_rd` stays 0.
- R13: A beat acknowledged with `beat_err`=1 sets flag bit 2, leaves `remain` unchanged, and clears `en_rd` at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable request (0 asks the stream to stop) |
| cfg_dir | input | 1 | 1 = memory to peripheral, 0 = peripheral to memory |
| cfg_circ | input | 1 | Circular mode |
| cfg_dbuf | input | 1 | Double-buffer mode |
| cfg_ct | input | 1 | Starting buffer in double-buffer mode |
| cfg_pfc | input | 1 | Peripheral is the flow controller |
| cfg_minc | input | 1 | Memory address increment |
| cfg_pinc | input | 1 | Peripheral address increment |
| cfg_size | input | 2 | Item size, 1<<size bytes |
| cfg_chsel | input | 3 | Request channel select passed to the beat |
| cfg_count | input | CW | Item count |
| cfg_m0addr | input | AW | Memory buffer 0 base |
| cfg_m1addr | input | AW | Memory buffer 1 base |
| cfg_paddr | input | AW | Peripheral address |
| cfg_fifo_en | input | 1 | FIFO mode in use |
| cfg_fth | input | 2 | FIFO threshold, quarters minus one |
| cfg_mburst | input | 2 | Memory burst size code |
| cfg_ie | input | 3 | Interrupt enables: half, complete, error |
| req | input | 1 | Peripheral request strobe |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| beat_ack | input | 1 | Beat acknowledged by the bus |
| beat_err | input | 1 | Acknowledged beat failed |
| beat_vld | output | 1 | Beat in flight |
| beat_wr | output | 1 | Beat direction (copy of the programmed direction) |
| beat_maddr | output | AW | Memory address of the beat |
| beat_paddr | output | AW | Peripheral address of the beat |
| beat_chsel | output | 3 | Channel select of the beat |
| en_rd | output | 1 | Enable read-back |
| ct_rd | output | 1 | Current buffer read-back |
| remain | output | CW | Remaining-item counter |
| flags | output | 4 | Sticky flags: 0 half, 1 complete, 2 bus error, 3 FIFO error |
| irq | output | 1 | Interrupt |

## Verification
A final beat can set the complete flag in the same cycle that software writes a one to its clear bit. The bench provokes this by driving `flag_clr` bit 1 on the same falling edge on which the bus model raises `beat_ack` for a one-item transfer. It then expects the flag to read 1 afterwards. A second collision comes from a stop request made while a beat is outstanding. The stop and the acknowledgement overlap, and the bench requires `en_rd` to stay at 1 until the acknowledgement has been counted.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int NFLAGS = 4;
    localparam int FLG_HALF = 0;
    localparam int FLG_DONE = 1;
    localparam int FLG_BUS  = 2;
    localparam int FLG_FIFO = 3;

    localparam int IE_HALF = 0;
    localparam int IE_DONE = 1;
    localparam int IE_ERR  = 2;
endpackage

// File: rtl/dma_seq_fifochk.sv
// Decides whether a FIFO threshold holds a whole number of memory bursts.
module dma_seq_fifochk #(
    parameter int FIFO_BYTES = 16
) (
    input  logic [1:0] fth,
    input  logic [1:0] mburst,
    input  logic [1:0] size,
    output logic       bad
);
    localparam int QUARTER = FIFO_BYTES / 4;

    logic [15:0] thr_bytes;
    logic [15:0] beats;
    logic [15:0] burst_bytes;

    always_comb begin
        thr_bytes   = 16'(({14'd0, fth} + 16'd1) * 16'(QUARTER));
        beats       = (mburst == 2'd0) ? 16'd1 : (16'd2 << mburst);
        burst_bytes = beats << size;
        bad         = (thr_bytes & (burst_bytes - 16'd1)) != 16'd0;
    end
endmodule

// File: rtl/dma_seq_flags.sv
// Sticky flag bank; a set in the same cycle as a clear wins.
module dma_seq_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_d;
        always_comb begin
            bit_d = q_o[i];
            if (clr_i[i]) bit_d = 1'b0;
            if (set_i[i]) bit_d = 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o[i] <= 1'b0;
            else        q_o[i] <= bit_d;
        end
    end
endmodule

// File: rtl/dma_stream_seq.sv
module dma_stream_seq
    import dma_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 16,
    parameter int FIFO_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_en,
    input  logic          cfg_dir,
    input  logic          cfg_circ,
    input  logic          cfg_dbuf,
    input  logic          cfg_ct,
    input  logic          cfg_pfc,
    input  logic          cfg_minc,
    input  logic          cfg_pinc,
    input  logic [1:0]    cfg_size,
    input  logic [2:0]    cfg_chsel,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cfg_m0addr,
    input  logic [AW-1:0] cfg_m1addr,
    input  logic [AW-1:0] cfg_paddr,
    input  logic          cfg_fifo_en,
    input  logic [1:0]    cfg_fth,
    input  logic [1:0]    cfg_mburst,
    input  logic [2:0]    cfg_ie,
    input  logic          req,
    input  logic [3:0]    flag_clr,
    input  logic          beat_ack,
    input  logic          beat_err,
    output logic          beat_vld,
    output logic          beat_wr,
    output logic [AW-1:0] beat_maddr,
    output logic [AW-1:0] beat_paddr,
    output logic [2:0]    beat_chsel,
    output logic          en_rd,
    output logic          ct_rd,
    output logic [CW-1:0] remain,
    output logic [3:0]    flags,
    output logic          irq
);
    localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic          en;
        logic          busy;
        logic          stop;
        logic          pend;
        logic          ct;
        logic          circ;
        logic          dbuf;
        logic          dir;
        logic          minc;
        logic          pinc;
        logic [1:0]    size;
        logic [2:0]    chsel;
        logic [2:0]    ie;
        logic [CW-1:0] prog;
        logic [CW-1:0] remain;
        logic [AW-1:0] m0;
        logic [AW-1:0] m1;
        logic [AW-1:0] pbase;
        logic [AW-1:0] maddr;
        logic [AW-1:0] paddr;
    } seq_t;

    seq_t              st_d, st_q;
    logic [NFLAGS-1:0] flg_set, flg_q;
    logic              pair_bad;
    logic              issue;
    logic              nxt_ct;
    logic [CW-1:0]     rem_n;
    logic [AW-1:0]     step;

    dma_seq_fifochk #(.FIFO_BYTES(FIFO_BYTES)) u_fifochk (
        .fth   (cfg_fth),
        .mburst(cfg_mburst),
        .size  (cfg_size),
        .bad   (pair_bad)
    );

    dma_seq_flags #(.N(NFLAGS)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(flg_set),
        .clr_i(flag_clr),
        .q_o  (flg_q)
    );

    always_comb begin
        st_d    = st_q;
        flg_set = '0;
        step    = ONE_A << st_q.size;
        rem_n   = st_q.remain - {{(CW-1){1'b0}}, 1'b1};
        nxt_ct  = st_q.dbuf ? ~st_q.ct : st_q.ct;
        issue   = st_q.en && !st_q.busy && !st_q.stop && (req || st_q.pend);

        // request capture and beat launch
        if (st_q.en) st_d.pend = issue ? (st_q.pend && req) : (st_q.pend || req);
        else         st_d.pend = 1'b0;
        if (issue) st_d.busy = 1'b1;

        // a pending stop completes once nothing is in flight
        if (st_q.en && st_q.stop && !st_q.busy) begin
            st_d.en   = 1'b0;
            st_d.stop = 1'b0;
            st_d.pend = 1'b0;
        end

        if (cfg_we) begin
            if (st_q.en) begin
                if (!cfg_en) begin
                    if (st_q.busy || issue) begin
                        st_d.stop = 1'b1;
                    end else begin
                        st_d.en   = 1'b0;
                        st_d.pend = 1'b0;
                    end
                end
            end else begin
                st_d.ct     = cfg_ct;
                st_d.circ   = cfg_circ;
                st_d.dbuf   = cfg_dbuf;
                st_d.dir    = cfg_dir;
                st_d.minc   = cfg_minc;
                st_d.pinc   = cfg_pinc;
                st_d.size   = cfg_size;
                st_d.chsel  = cfg_chsel;
                st_d.ie     = cfg_ie;
                st_d.m0     = cfg_m0addr;
                st_d.m1     = cfg_m1addr;
                st_d.pbase  = cfg_paddr;
                st_d.paddr  = cfg_paddr;
                st_d.maddr  = (cfg_dbuf && cfg_ct) ? cfg_m1addr : cfg_m0addr;
                st_d.prog   = cfg_pfc ? '1 : cfg_count;
                st_d.remain = cfg_pfc ? '1 : cfg_count;
                if (cfg_en && flg_q == '0) begin
                    if (cfg_fifo_en && pair_bad) flg_set[FLG_FIFO] = 1'b1;
                    else                         st_d.en = 1'b1;
                end
            end
        end

        // beat completion
        if (st_q.busy && beat_ack) begin
            st_d.busy = 1'b0;
            if (beat_err) begin
                flg_set[FLG_BUS] = 1'b1;
                st_d.en   = 1'b0;
                st_d.stop = 1'b0;
                st_d.pend = 1'b0;
            end else begin
                st_d.remain = rem_n;
                if (st_q.minc) st_d.maddr = st_q.maddr + step;
                if (st_q.pinc) st_d.paddr = st_q.paddr + step;
                if (rem_n == (st_q.prog >> 1)) flg_set[FLG_HALF] = 1'b1;
                if (rem_n == '0) begin
                    flg_set[FLG_DONE] = 1'b1;
                    if (st_q.circ || st_q.dbuf) begin
                        st_d.remain = st_q.prog;
                        st_d.ct     = nxt_ct;
                        st_d.maddr  = (st_q.dbuf && nxt_ct) ? st_q.m1 : st_q.m0;
                        st_d.paddr  = st_q.pbase;
                    end else begin
                        st_d.en   = 1'b0;
                        st_d.pend = 1'b0;
                    end
                end
                if (st_q.stop) begin
                    st_d.en   = 1'b0;
                    st_d.stop = 1'b0;
                    st_d.pend = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_vld   = st_q.busy;
    assign beat_wr    = st_q.dir;
    assign beat_maddr = st_q.maddr;
    assign beat_paddr = st_q.paddr;
    assign beat_chsel = st_q.chsel;
    assign en_rd      = st_q.en;
    assign ct_rd      = st_q.ct;
    assign remain     = st_q.remain;
    assign flags      = flg_q;
    assign irq        = (flg_q[FLG_HALF] & st_q.ie[IE_HALF])
                      | (flg_q[FLG_DONE] & st_q.ie[IE_DONE])
                      | ((flg_q[FLG_BUS] | flg_q[FLG_FIFO]) & st_q.ie[IE_ERR]);
endmodule

// File: rtl/dma_stream_seq_chk.sv
module dma_stream_seq_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          cfg_en,
    input logic [3:0]    flag_clr,
    input logic          beat_vld,
    input logic          beat_ack,
    input logic          beat_err,
    input logic [AW-1:0] beat_maddr,
    input logic          en_rd,
    input logic [CW-1:0] remain,
    input logic [3:0]    flags,
    input logic          circ,
    input logic          dbuf
);
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld && beat_ack && !beat_err && remain > CW'(1)
        |=> remain == CW'($past(remain) - CW'(1)));

    a_r5_normal_stop: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld && beat_ack && !beat_err && remain == CW'(1) && !circ && !dbuf
        |=> !en_rd && remain == '0);

    a_r8_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld && !beat_ack |=> beat_vld && en_rd && $stable(beat_maddr));

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flags[1] && !flag_clr[1] |=> flags[1]);

    a_r12_refuse_enable: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_en && !en_rd && flags != 4'd0 |=> !en_rd);

    a_r13_bus_error: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld && beat_ack && beat_err |=> !en_rd && flags[2]);
endmodule

bind dma_stream_seq dma_stream_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_en    (cfg_en),
    .flag_clr  (flag_clr),
    .beat_vld  (beat_vld),
    .beat_ack  (beat_ack),
    .beat_err  (beat_err),
    .beat_maddr(beat_maddr),
    .en_rd     (en_rd),
    .remain    (remain),
    .flags     (flags),
    .circ      (st_q.circ),
    .dbuf      (st_q.dbuf)
);

// File: tb/dma_stream_seq_bench.sv
module dma_stream_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;

    // {fth[1:0], mburst[1:0], size[1:0], expect_fifo_error}
    localparam logic [6:0] PAIR_TAB [10] = '{
        7'b11_00_10_0, 7'b00_01_00_0, 7'b00_01_01_1, 7'b01_01_01_0,
        7'b10_01_01_1, 7'b10_01_10_1, 7'b11_01_10_0, 7'b11_10_10_1,
        7'b01_10_00_0, 7'b00_11_00_1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_en = 0, cfg_dir = 0, cfg_circ = 0, cfg_dbuf = 0, cfg_ct = 0;
    logic cfg_pfc = 0, cfg_minc = 0, cfg_pinc = 0, cfg_fifo_en = 0;
    logic [1:0] cfg_size = 0, cfg_fth = 0, cfg_mburst = 0;
    logic [2:0] cfg_chsel = 3'd5, cfg_ie = 0;
    logic [CW-1:0] cfg_count = 0;
    logic [AW-1:0] cfg_m0addr = 0, cfg_m1addr = 0, cfg_paddr = 0;
    logic req = 0;
    logic [3:0] flag_clr = 0;
    logic beat_ack, beat_err;
    logic beat_vld, beat_wr, en_rd, ct_rd, irq;
    logic [AW-1:0] beat_maddr, beat_paddr;
    logic [2:0] beat_chsel;
    logic [CW-1:0] remain;
    logic [3:0] flags;

    int total = 0;
    int bad = 0;
    int lat = 1;
    logic inject_err = 0;
    logic [AW-1:0] log_m, log_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_stream_seq u_dma_stream_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
        .cfg_circ(cfg_circ), .cfg_dbuf(cfg_dbuf), .cfg_ct(cfg_ct), .cfg_pfc(cfg_pfc),
        .cfg_minc(cfg_minc), .cfg_pinc(cfg_pinc), .cfg_size(cfg_size), .cfg_chsel(cfg_chsel),
        .cfg_count(cfg_count), .cfg_m0addr(cfg_m0addr), .cfg_m1addr(cfg_m1addr),
        .cfg_paddr(cfg_paddr), .cfg_fifo_en(cfg_fifo_en), .cfg_fth(cfg_fth),
        .cfg_mburst(cfg_mburst), .cfg_ie(cfg_ie), .req(req), .flag_clr(flag_clr),
        .beat_ack(beat_ack), .beat_err(beat_err), .beat_vld(beat_vld), .beat_wr(beat_wr),
        .beat_maddr(beat_maddr), .beat_paddr(beat_paddr), .beat_chsel(beat_chsel),
        .en_rd(en_rd), .ct_rd(ct_rd), .remain(remain), .flags(flags), .irq(irq)
    );

    // bus model: acknowledges a beat after lat falling edges
    initial begin
        int wcnt;
        wcnt = 0;
        beat_ack = 1'b0;
        beat_err = 1'b0;
        forever begin
            @(negedge clk);
            beat_ack = 1'b0;
            beat_err = 1'b0;
            if (beat_vld) begin
                wcnt++;
                if (wcnt >= lat) begin
                    beat_ack   = 1'b1;
                    beat_err   = inject_err;
                    inject_err = 1'b0;
                    log_m      = beat_maddr;
                    log_p      = beat_paddr;
                    wcnt       = 0;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic en, input logic circ, input logic dbuf, input logic ct,
                       input logic pfc, input logic minc, input logic pinc,
                       input logic [1:0] sz, input logic [15:0] cnt,
                       input logic [31:0] m0, input logic [31:0] m1, input logic [31:0] pa,
                       input logic fen, input logic [1:0] fth, input logic [1:0] mb,
                       input logic [2:0] ie);
        @(negedge clk);
        cfg_we = 1; cfg_en = en; cfg_circ = circ; cfg_dbuf = dbuf; cfg_ct = ct;
        cfg_pfc = pfc; cfg_minc = minc; cfg_pinc = pinc; cfg_size = sz; cfg_count = cnt;
        cfg_m0addr = m0; cfg_m1addr = m1; cfg_paddr = pa; cfg_fifo_en = fen;
        cfg_fth = fth; cfg_mburst = mb; cfg_ie = ie;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic stop_idle();
        cfg(0, 0, 0, 0, 0, 0, 0, 2'd0, 16'd0, 0, 0, 0, 0, 2'd0, 2'd0, 3'd0);
    endtask

    task automatic clr_all();
        @(negedge clk); flag_clr = 4'hF;
        @(negedge clk); flag_clr = 4'h0;
    endtask

    task automatic req_pulse();
        @(negedge clk); req = 1;
        @(negedge clk); req = 0;
    endtask

    task automatic item();
        req_pulse();
        repeat (lat + 2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 en", en_rd, 0);
        check("R1 flags", flags, 0);
        check("R1 vld/irq/ct", {beat_vld, irq, ct_rd}, 0);
        check("R1 remain", remain, 0);

        // R10 threshold / burst pairing table
        for (int i = 0; i < 10; i++) begin
            clr_all();
            cfg(1, 0, 0, 0, 0, 1, 0, PAIR_TAB[i][2:1], 16'd4, 32'h0, 32'h0, 32'h0,
                1, PAIR_TAB[i][6:5], PAIR_TAB[i][4:3], 3'd0);
            check("R10 enable result", en_rd, !PAIR_TAB[i][0]);
            check("R10 fifo flag", flags[3], PAIR_TAB[i][0]);
            if (en_rd) stop_idle();
        end
        clr_all();

        // R2 R3 R4 R5 normal mode, word items, memory increment only
        cfg(1, 0, 0, 0, 0, 1, 0, 2'd2, 16'd4, 32'h100, 32'h0, 32'h40, 0, 2'd0, 2'd0, 3'b001);
        check("R2 enabled", en_rd, 1);
        check("R2 loaded count", remain, 4);
        item();
        check("R2 remain after 1", remain, 3);
        check("R3 first maddr", log_m, 32'h100);
        item();
        check("R4 half flag", flags[0], 1);
        check("R4 irq from half", irq, 1);
        check("R4 no complete yet", flags[1], 0);
        item();
        item();
        check("R3 last maddr", log_m, 32'h10C);
        check("R3 paddr fixed", log_p, 32'h40);
        check("R4 complete flag", flags[1], 1);
        check("R5 stopped", en_rd, 0);
        check("R5 remain zero", remain, 0);

        // R12 refused while flags set, then R11 clear
        cfg(1, 0, 0, 0, 0, 1, 0, 2'd2, 16'd4, 32'h100, 32'h0, 32'h40, 0, 2'd0, 2'd0, 3'd0);
        check("R12 refused", en_rd, 0);
        clr_all();
        check("R11 cleared", flags, 0);

        // R6 circular, halfword items, both increments
        cfg(1, 1, 0, 0, 0, 1, 1, 2'd1, 16'd3, 32'h80, 32'h0, 32'h10, 0, 2'd0, 2'd0, 3'd0);
        item(); item();
        check("R4 half at prog>>1", flags[0], 1);
        item();
        check("R3 paddr incremented", log_p, 32'h14);
        check("R6 reloaded", remain, 3);
        check("R6 still enabled", en_rd, 1);
        check("R6 complete on wrap", flags[1], 1);
        item();
        check("R6 maddr back to base", log_m, 32'h80);
        check("R6 paddr back to base", log_p, 32'h10);
        stop_idle();
        check("R8 idle stop immediate", en_rd, 0);
        clr_all();

        // R7 double buffer
        cfg(1, 0, 1, 0, 0, 1, 0, 2'd0, 16'd2, 32'h200, 32'h300, 32'h0, 0, 2'd0, 2'd0, 3'd0);
        item(); item();
        check("R7 second byte", log_m, 32'h201);
        check("R7 ct toggled", ct_rd, 1);
        check("R7 reloaded", remain, 2);
        item();
        check("R7 buffer 1 base", log_m, 32'h300);
        item();
        check("R7 ct back", ct_rd, 0);
        check("R7 still enabled", en_rd, 1);
        item();
        check("R7 buffer 0 base", log_m, 32'h200);
        stop_idle();
        clr_all();

        // R8 deferred stop with a slow bus, plus write ignored while enabled
        lat = 6;
        cfg(1, 0, 0, 0, 0, 1, 0, 2'd2, 16'd4, 32'h0, 32'h0, 32'h0, 0, 2'd0, 2'd0, 3'd0);
        req_pulse();
        cfg(0, 0, 0, 0, 0, 0, 0, 2'd0, 16'd9, 32'h0, 32'h0, 32'h0, 0, 2'd0, 2'd0, 3'd0);
        check("R8 still enabled in flight", en_rd, 1);
        check("R8 beat in flight", beat_vld, 1);
        repeat (6) @(negedge clk);
        check("R8 stopped after beat", en_rd, 0);
        check("R8 beat counted, count write ignored", remain, 3);
        lat = 1;

        // R13 bus error
        cfg(1, 0, 0, 0, 0, 1, 0, 2'd2, 16'd4, 32'h0, 32'h0, 32'h0, 0, 2'd0, 2'd0, 3'd0);
        inject_err = 1;
        item();
        check("R13 stopped", en_rd, 0);
        check("R13 error flag", flags[2], 1);
        check("R13 remain unchanged", remain, 4);
        check("R4 error irq masked", irq, 0);
        clr_all();

        // R9 peripheral flow control
        cfg(1, 0, 0, 0, 1, 0, 0, 2'd0, 16'd5, 32'h0, 32'h0, 32'h0, 0, 2'd0, 2'd0, 3'd0);
        check("R9 forced count", remain, 16'hFFFF);
        item();
        check("R9 decrement", remain, 16'hFFFE);
        stop_idle();
        clr_all();

        // R11 set and clear in the same cycle: set wins
        cfg(1, 0, 0, 0, 0, 0, 0, 2'd0, 16'd1, 32'h0, 32'h0, 32'h0, 0, 2'd0, 2'd0, 3'd0);
        @(negedge clk); req = 1;
        @(negedge clk); req = 0; flag_clr = 4'b0010;
        @(negedge clk); flag_clr = 4'b0000;
        check("R11 set beats clear", flags[1], 1);
        check("R5 one item done", en_rd, 0);
        @(negedge clk); flag_clr = 4'b0010;
        @(negedge clk); flag_clr = 4'b0000;
        check("R11 clear only that bit", flags, 4'b0001);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule